// File: doc/BRIEF.md
# Bit-Serial Logic Processor

This block keeps two 8-bit operand registers, A and B, and combines them with a bitwise logical operation. It does not use a parallel 8-bit unit. Both registers shift right, one bit per clock. On each shift, their lowest bits enter a 1-bit logic unit. A router then decides what each register takes into its vacated top bit: its own outgoing bit, which recirculates, or the logic result. After eight shifts every bit has made one trip through the unit. Each register then holds either its original value or the bitwise result.

To use the block, load the operands from the 8-bit data input while the block is idle. Choose a function code and a routing code. Then raise the execute input. A busy flag covers the eight shift clocks, and a one-cycle done pulse follows them. The LED output always shows register A. Register B can be read through the normal interface: clear A, then run XOR with the result routed into A.

Top module: `serial_logic_proc`

## Requirements
- R1: A synchronous active-high reset clears both registers, the step counter, the busy flag and the done pulse. After reset, `led_o` reads 0x00, and `busy_o` and `done_o` are low.
- R2: While idle, `load_a_i` copies `data_i` into A and `load_b_i` copies it into B at the next clock. Both may be asserted together. With no load and no run, both registers hold.
- R3: If `exec_i` is sampled high at a clock edge where it was low at the previous edge and the block is idle, `busy_o` is high from the next cycle for exactly 8 cycles.
- R4: `done_o` is high for exactly one cycle, the cycle right after the last busy cycle.
- R5: Rising edges of `exec_i` during a run are ignored. Holding `exec_i` high past the end of a run does not start another.
- R6: `load_a_i` and `load_b_i` are ignored while `busy_o` is high.
- R7: Each busy cycle shifts both registers right by one, taking the least significant bit out first. After k shifts with routing 00, A equals its start value rotated right by k.
- R8: `func_i` selects the 1-bit operation on the outgoing A bit a and B bit b: 000 a&b, 001 a|b, 010 a^b, 011 ~(a&b), 100 ~(a|b), 101 ~(a^b), 110 ~a, 111 a.
- R9: `route_i` bit 0 set feeds the result into A, and bit 1 set feeds it into B. A cleared bit makes that register recirculate its own bit. 00 keeps both, 01 writes A, 10 writes B, 11 writes both. After a run, a written register holds the bitwise result.
- R10: `led_o` always shows the current contents of register A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_i | input | 1 | Execute request, rising edge starts a run |
| load_a_i | input | 1 | Load `data_i` into register A when idle |
| load_b_i | input | 1 | Load `data_i` into register B when idle |
| data_i | input | 8 | Operand data |
| func_i | input | 3 | Logic function select |
| route_i | input | 2 | Write-back routing select |
| led_o | output | 8 | Contents of register A |
| busy_o | output | 1 | High during the eight shift cycles |
| done_o | output | 1 | One-cycle pulse after a run |

## Verification
On every cycle the assertions check the control timing: a start follows an idle rising edge, a run lasts exactly eight cycles, and the done pulse sits right after it. They also check that A rotates on each busy cycle whenever A recirculates, and that A holds when idle and not loaded. Only the bench scenarios can show that each function code and routing code leaves the right bitwise result in each register. The same holds for the contents of B, which the bench reads back through an XOR run, and for the rule that loads and execute edges during a run leave the result untouched.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        FN_AND  = 3'b000,
        FN_OR   = 3'b001,
        FN_XOR  = 3'b010,
        FN_NAND = 3'b011,
        FN_NOR  = 3'b100,
        FN_XNOR = 3'b101,
        FN_INVA = 3'b110,
        FN_PASA = 3'b111
    } func_e;

    localparam int ROUTE_TO_A = 0;
    localparam int ROUTE_TO_B = 1;

endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic exec_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          exec_prev;
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.exec_prev = exec_i;
        st_d.done      = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == CW'(W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (exec_i && !st_q.exec_prev) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
endmodule

// File: rtl/slp_bitop.sv
module slp_bitop
    import slp_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic [2:0] func_i,
    output logic       y_o
);
    always_comb begin
        unique case (func_e'(func_i))
            FN_AND:  y_o = a_i & b_i;
            FN_OR:   y_o = a_i | b_i;
            FN_XOR:  y_o = a_i ^ b_i;
            FN_NAND: y_o = ~(a_i & b_i);
            FN_NOR:  y_o = ~(a_i | b_i);
            FN_XNOR: y_o = ~(a_i ^ b_i);
            FN_INVA: y_o = ~a_i;
            FN_PASA: y_o = a_i;
            default: y_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/slp_router.sv
module slp_router
    import slp_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       y_i,
    input  logic [1:0] route_i,
    output logic       new_a_o,
    output logic       new_b_o
);
    always_comb begin
        new_a_o = route_i[ROUTE_TO_A] ? y_i : a_i;
        new_b_o = route_i[ROUTE_TO_B] ? y_i : b_i;
    end
endmodule

// File: rtl/serial_logic_proc.sv
module serial_logic_proc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec_i,
    input  logic         load_a_i,
    input  logic         load_b_i,
    input  logic [W-1:0] data_i,
    input  logic [2:0]   func_i,
    input  logic [1:0]   route_i,
    output logic [W-1:0] led_o,
    output logic         busy_o,
    output logic         done_o
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  shift_en;
    logic  res_bit;
    logic  feed_a, feed_b;

    slp_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .exec_i (exec_i),
        .busy_o (shift_en),
        .done_o (done_o)
    );

    slp_bitop u_bitop (
        .a_i    (rg_q.a[0]),
        .b_i    (rg_q.b[0]),
        .func_i (func_i),
        .y_o    (res_bit)
    );

    slp_router u_router (
        .a_i     (rg_q.a[0]),
        .b_i     (rg_q.b[0]),
        .y_i     (res_bit),
        .route_i (route_i),
        .new_a_o (feed_a),
        .new_b_o (feed_b)
    );

    always_comb begin
        rg_d = rg_q;
        if (shift_en) begin
            rg_d.a = {feed_a, rg_q.a[W-1:1]};
            rg_d.b = {feed_b, rg_q.b[W-1:1]};
        end else begin
            if (load_a_i) rg_d.a = data_i;
            if (load_b_i) rg_d.b = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rg_q <= '0;
        else     rg_q <= rg_d;
    end

    assign led_o  = rg_q.a;
    assign busy_o = shift_en;
endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         exec_i,
    input logic         load_a_i,
    input logic [1:0]   route_i,
    input logic [W-1:0] led_o,
    input logic         busy_o,
    input logic         done_o
);
    localparam int RW = $clog2(W + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    a_r3_start_after_edge: assert property (@(posedge clk) disable iff (rst)
        ($rose(exec_i) && !busy_o) |=> busy_o);

    a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == RW'(W)));

    a_r5_no_overlong_run: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < RW'(W)));

    a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r7_a_rotates: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !route_i[0]) |=> (led_o == {$past(led_o[0]), $past(led_o[W-1:1])}));

    a_r2_a_holds_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !load_a_i) |=> $stable(led_o));
endmodule

bind serial_logic_proc slp_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .exec_i   (exec_i),
    .load_a_i (load_a_i),
    .route_i  (route_i),
    .led_o    (led_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/serial_logic_proc_tb.sv
module serial_logic_proc_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_i = 1'b0, load_a_i = 1'b0, load_b_i = 1'b0;
    logic [7:0] data_i = '0;
    logic [2:0] func_i = '0;
    logic [1:0] route_i = '0;
    logic [7:0] led_o;
    logic       busy_o, done_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    serial_logic_proc u_dut (
        .clk(clk), .rst(rst), .exec_i(exec_i), .load_a_i(load_a_i),
        .load_b_i(load_b_i), .data_i(data_i), .func_i(func_i),
        .route_i(route_i), .led_o(led_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [7:0] ref_op(input logic [2:0] f, input logic [7:0] a, input logic [7:0] b);
        case (f)
            3'b000: return a & b;
            3'b001: return a | b;
            3'b010: return a ^ b;
            3'b011: return ~(a & b);
            3'b100: return ~(a | b);
            3'b101: return ~(a ^ b);
            3'b110: return ~a;
            default: return a;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic la, input logic lb, input logic [7:0] d);
        @(negedge clk);
        load_a_i = la; load_b_i = lb; data_i = d;
        @(negedge clk);
        load_a_i = 1'b0; load_b_i = 1'b0;
    endtask

    // pulse exec, count busy cycles, check length and done pulse
    task automatic run(input logic [2:0] f, input logic [1:0] r);
        int n;
        func_i = f; route_i = r;
        @(negedge clk); exec_i = 1'b1;
        @(negedge clk); exec_i = 1'b0;
        n = 0;
        while (busy_o && n < 20) begin n++; @(negedge clk); end
        check("R3 busy length", n, 8);
        check("R4 done after run", done_o, 1);
        @(negedge clk);
        check("R4 done one cycle", done_o, 0);
    endtask

    task automatic read_b(output logic [7:0] bval);
        load(1'b1, 1'b0, 8'h00);
        run(3'b010, 2'b01);
        bval = led_o;
    endtask

    task automatic t_reset();
        check("R1 led after reset", led_o, 8'h00);
        check("R1 busy after reset", busy_o, 0);
        check("R1 done after reset", done_o, 0);
    endtask

    task automatic t_load();
        logic [7:0] bv;
        load(1'b1, 1'b1, 8'h3C);
        check("R2 load both A", led_o, 8'h3C);
        read_b(bv);
        check("R2 load both B", bv, 8'h3C);
        load(1'b1, 1'b0, 8'hA5);
        check("R10 led shows A", led_o, 8'hA5);
        repeat (3) @(negedge clk);
        check("R2 A holds idle", led_o, 8'hA5);
    endtask

    task automatic t_funcs();
        logic [7:0] a0, b0, bv;
        a0 = 8'b1100_1010; b0 = 8'b1010_0110;
        for (int f = 0; f < 8; f++) begin
            load(1'b1, 1'b0, a0);
            load(1'b0, 1'b1, b0);
            run(3'(f), 2'b01);
            check($sformatf("R8 func %0d into A", f), led_o, ref_op(3'(f), a0, b0));
            read_b(bv);
            check("R9 B kept on route 01", bv, b0);
        end
    endtask

    task automatic t_routes();
        logic [7:0] a0, b0, bv;
        a0 = 8'h5E; b0 = 8'hC3;
        for (int r = 0; r < 4; r++) begin
            load(1'b1, 1'b1, a0);
            load(1'b0, 1'b1, b0);
            run(3'b001, 2'(r));
            check($sformatf("R9 route %0d A", r), led_o, r[0] ? (a0 | b0) : a0);
            read_b(bv);
            check($sformatf("R9 route %0d B", r), bv, r[1] ? (a0 | b0) : b0);
        end
    endtask

    task automatic t_partial_shift();
        load(1'b1, 1'b0, 8'b1000_0110);
        route_i = 2'b00;
        @(negedge clk); exec_i = 1'b1;
        @(negedge clk); exec_i = 1'b0;
        check("R7 no shift on start", led_o, 8'b1000_0110);
        repeat (4) @(negedge clk);
        check("R7 rotate right by 4", led_o, 8'b0110_1000);
        repeat (4) @(negedge clk);
        check("R7 back after 8", led_o, 8'b1000_0110);
        check("R4 done", done_o, 1);
        @(negedge clk);
    endtask

    task automatic t_ignore_busy();
        logic [7:0] bv;
        load(1'b1, 1'b0, 8'hF0);
        load(1'b0, 1'b1, 8'h33);
        func_i = 3'b010; route_i = 2'b01;
        @(negedge clk); exec_i = 1'b1;
        @(negedge clk); exec_i = 1'b0;
        @(negedge clk); load_a_i = 1'b1; load_b_i = 1'b1; data_i = 8'h99;
        @(negedge clk); load_a_i = 1'b0; load_b_i = 1'b0; exec_i = 1'b1;
        repeat (8) @(negedge clk);
        check("R5 no restart while exec held", busy_o, 0);
        check("R6 A load ignored", led_o, 8'hF0 ^ 8'h33);
        @(negedge clk);
        check("R5 still idle", busy_o, 0);
        exec_i = 1'b0;
        read_b(bv);
        check("R6 B load ignored", bv, 8'h33);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_funcs();
        t_routes();
        t_partial_shift();
        t_ignore_busy();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule